// File: doc/BRIEF.md
# Delayed Lockstep Output Comparator

This block watches two redundant cores that run the same instruction stream. The checker core runs a fixed number of clock cycles behind the master core, two by default. The comparator holds each master output word and its valid qualifier in a short delay line until the checker produces the matching word. It then compares the two. Any difference drives an alarm.

The alarm is a registered pulse, high for one cycle for each cycle that mismatches. A sticky error flag is set together with the alarm and stays set until the error-clear input is raised. Comparison only starts once the delay line holds real master data after reset, and it stops while the enable input is low. A build option decides what happens when both sides are idle: the data words are either ignored or still compared. The comparison is split into lanes so that the compare tree keeps a shallow logic depth on wide buses.

Top module: `lockstep_cmp`

## Requirements
- R1: While reset is asserted, and in the first sampled cycle after it, both `alarm_o` and `err_sticky_o` are 0.
- R2: When the checker presents the master's valid and data exactly LAG cycles later (LAG = 2 by default), `alarm_o` stays 0 for every valid/data pattern.
- R3: When both delayed master valid and checker valid are 1 and the data words differ in any bit, `alarm_o` is 1 in the cycle after the one in which the pair meets at the comparator.
- R4: A difference in the valid bit alone, with equal data, counts as a mismatch. This holds in both directions: master 1 with checker 0, and master 0 with checker 1.
- R5: In the default mode (compare data only when valid), a data difference while both valid bits are 0 raises no alarm and leaves the sticky flag clear.
- R6: When `enable_i` is 0 in the comparison cycle, a mismatch raises no alarm and does not set the sticky flag.
- R7: In the first LAG cycles after reset is released (cycles 0 and 1 by default), mismatches are ignored. In cycle LAG, comparison is live.
- R8: `alarm_o` is high for exactly the cycles that follow mismatching cycles. It returns to 0 after the first matching cycle, and back-to-back mismatches hold it high.
- R9: `err_sticky_o` rises together with `alarm_o` and stays 1 until `err_clear_i` is 1 in a cycle with no mismatch, after which it reads 0. A mismatch in the same cycle as a clear leaves the flag at 1.
- R10: A checker stream that is only one cycle behind, instead of LAG, is reported as a mismatch whenever consecutive master words differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Allows comparison when 1 |
| mst_valid_i | input | 1 | Master output valid qualifier |
| mst_data_i | input | DATA_W | Master output bundle |
| chk_valid_i | input | 1 | Checker output valid qualifier |
| chk_data_i | input | DATA_W | Checker output bundle |
| err_clear_i | input | 1 | Clears the sticky error flag |
| alarm_o | output | 1 | One-cycle pulse per mismatching cycle |
| err_sticky_o | output | 1 | Sticky mismatch flag |

## Verification
Several rules are checked by assertions on every clock: the alarm always implies the sticky flag, the flag holds while no clear is raised, the alarm stays low while the block is disabled or not yet armed, a valid-only split always produces an alarm, and the arming state never falls back once set. Only the bench scenarios can show the end-to-end timing. These cover the exact cycle in which an alarm appears relative to the master word, the lag-aligned streams that must stay quiet, idle data being ignored, the collision of a clear with a new mismatch, and the detection of a checker running at the wrong lag.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;

   // How the data words are treated when the valid qualifiers agree on idle
   typedef enum logic [0:0] {
      CMP_VALID_ONLY = 1'b0,   // data compared only when both sides are valid
      CMP_ALWAYS     = 1'b1    // data compared in every armed cycle
   } cmp_mode_e;

   localparam int unsigned MAX_LAG = 8;

endpackage

// File: rtl/lockstep_delay.sv
// Fixed-depth shift line that holds the master bundle until the checker
// catches up.
module lockstep_delay #(
   parameter int unsigned WIDTH = 33,
   parameter int unsigned DEPTH = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("lockstep_delay: DEPTH must be at least 1");
      end
      if (WIDTH < 2) begin : g_bad_width
         $error("lockstep_delay: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [DEPTH];

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stage_q[s] <= '0;
               else         stage_q[s] <= d_i;
            end
         end else begin : g_tail
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stage_q[s] <= '0;
               else         stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/lockstep_arm.sv
// Counts cycles after reset release and arms the comparator once the
// delay line holds real master data.
module lockstep_arm #(
   parameter int unsigned LAG = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic armed_o
);

   localparam int unsigned CW = (LAG < 1) ? 1 : $clog2(LAG + 1);
   localparam logic [CW-1:0] LIMIT = CW'(LAG);

   generate
      if (LAG < 1 || LAG > lockstep_pkg::MAX_LAG) begin : g_bad_lag
         $error("lockstep_arm: LAG out of range");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign armed_o = (cnt_q == LIMIT);

   p_armed_stays_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_o |=> armed_o);

endmodule

// File: rtl/lockstep_diff.sv
// Lane-split comparator with registered alarm pulse and sticky flag.
module lockstep_diff #(
   parameter int unsigned            DATA_W = 32,
   parameter int unsigned            LANE_W = 8,
   parameter lockstep_pkg::cmp_mode_e MODE  = lockstep_pkg::CMP_VALID_ONLY
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              armed_i,
   input  logic              enable_i,
   input  logic              ref_valid_i,
   input  logic [DATA_W-1:0] ref_data_i,
   input  logic              chk_valid_i,
   input  logic [DATA_W-1:0] chk_data_i,
   input  logic              clear_i,
   output logic              alarm_o,
   output logic              sticky_o
);

   localparam int unsigned NUM_LANES = (DATA_W + LANE_W - 1) / LANE_W;
   localparam int unsigned PAD_W     = NUM_LANES * LANE_W;

   generate
      if (LANE_W < 1 || LANE_W > DATA_W) begin : g_bad_lane
         $error("lockstep_diff: LANE_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [PAD_W-1:0]     ref_pad, chk_pad;
   logic [NUM_LANES-1:0] lane_ne;
   logic                 data_ne, valid_ne, data_bad, hit;
   logic                 alarm_q, sticky_q;

   assign ref_pad = PAD_W'(ref_data_i);
   assign chk_pad = PAD_W'(chk_data_i);

   generate
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         assign lane_ne[g] = |(ref_pad[g*LANE_W +: LANE_W] ^ chk_pad[g*LANE_W +: LANE_W]);
      end
   endgenerate

   assign data_ne  = |lane_ne;
   assign valid_ne = ref_valid_i ^ chk_valid_i;

   generate
      if (MODE == lockstep_pkg::CMP_ALWAYS) begin : g_always
         assign data_bad = data_ne;
      end else begin : g_valid_only
         assign data_bad = data_ne & ref_valid_i & chk_valid_i;
      end
   endgenerate

   assign hit = armed_i & enable_i & (valid_ne | data_bad);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         alarm_q  <= 1'b0;
         sticky_q <= 1'b0;
      end else begin
         alarm_q  <= hit;
         sticky_q <= (sticky_q & ~clear_i) | hit;
      end
   end

   assign alarm_o  = alarm_q;
   assign sticky_o = sticky_q;

   p_sticky_with_alarm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alarm_o |-> sticky_o);

   p_sticky_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sticky_o && !clear_i) |=> sticky_o);

   p_quiet_when_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!enable_i || !armed_i) |=> !alarm_o);

   p_valid_split_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_i && enable_i && (ref_valid_i != chk_valid_i)) |=> alarm_o);

endmodule

// File: rtl/lockstep_cmp.sv
// Top: delays the master bundle by LAG cycles and compares it with the
// checker bundle.
module lockstep_cmp #(
   parameter int unsigned            DATA_W = 32,
   parameter int unsigned            LAG    = 2,
   parameter int unsigned            LANE_W = 8,
   parameter lockstep_pkg::cmp_mode_e MODE  = lockstep_pkg::CMP_VALID_ONLY
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic              mst_valid_i,
   input  logic [DATA_W-1:0] mst_data_i,
   input  logic              chk_valid_i,
   input  logic [DATA_W-1:0] chk_data_i,
   input  logic              err_clear_i,
   output logic              alarm_o,
   output logic              err_sticky_o
);

   localparam int unsigned BUNDLE_W = DATA_W + 1;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("lockstep_cmp: DATA_W must be at least 1");
      end
   endgenerate

   logic [BUNDLE_W-1:0] mst_bundle, ref_bundle;
   logic                armed;

   assign mst_bundle = {mst_valid_i, mst_data_i};

   lockstep_delay #(.WIDTH(BUNDLE_W), .DEPTH(LAG)) u_delay (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (mst_bundle),
      .q_o   (ref_bundle)
   );

   lockstep_arm #(.LAG(LAG)) u_arm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .armed_o(armed)
   );

   lockstep_diff #(.DATA_W(DATA_W), .LANE_W(LANE_W), .MODE(MODE)) u_diff (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .armed_i    (armed),
      .enable_i   (enable_i),
      .ref_valid_i(ref_bundle[DATA_W]),
      .ref_data_i (ref_bundle[DATA_W-1:0]),
      .chk_valid_i(chk_valid_i),
      .chk_data_i (chk_data_i),
      .clear_i    (err_clear_i),
      .alarm_o    (alarm_o),
      .sticky_o   (err_sticky_o)
   );

   p_no_alarm_unarmed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alarm_o |-> $past(armed));

   p_sticky_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_sticky_o) |-> alarm_o);

endmodule

// File: tb/lockstep_cmp_tb.sv
module lockstep_cmp_tb;

   localparam int W = 32;

   logic         clk_i = 1'b0;
   logic         rst_ni = 1'b0;
   logic         enable_i = 1'b0;
   logic         mst_valid_i = 1'b0;
   logic [W-1:0] mst_data_i = '0;
   logic         chk_valid_i = 1'b0;
   logic [W-1:0] chk_data_i = '0;
   logic         err_clear_i = 1'b0;
   logic         alarm_o, err_sticky_o;

   int n_checks = 0;
   int n_fail   = 0;

   // stimulus-side history of the master stream (for lag alignment only)
   logic         p1v, p2v;
   logic [W-1:0] p1d, p2d;

   always #4ns clk_i = ~clk_i;   // 125 MHz

   lockstep_cmp #(.DATA_W(W)) u_dut (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .enable_i    (enable_i),
      .mst_valid_i (mst_valid_i),
      .mst_data_i  (mst_data_i),
      .chk_valid_i (chk_valid_i),
      .chk_data_i  (chk_data_i),
      .err_clear_i (err_clear_i),
      .alarm_o     (alarm_o),
      .err_sticky_o(err_sticky_o)
   );

   task automatic check(input logic act, input logic exp, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", what, act, exp);
      end
   endtask

   // Ends at a falling edge with reset released; next cycle is cycle 0.
   task automatic do_reset();
      rst_ni      = 1'b0;
      enable_i    = 1'b1;
      mst_valid_i = 1'b1;
      mst_data_i  = 32'hA5A5_0001;
      chk_valid_i = 1'b0;
      chk_data_i  = 32'h0;
      err_clear_i = 1'b0;
      p1v = 1'b0; p2v = 1'b0; p1d = '0; p2d = '0;
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      rst_ni = 1'b1;
   endtask

   // One cycle: drive at the falling edge, sample just after the rising edge.
   task automatic feed(input logic mv, input logic [W-1:0] md, input logic en,
                       input logic clr, input logic vflip, input logic [W-1:0] dx,
                       input logic short_lag, input logic ea, input logic es,
                       input string tag);
      mst_valid_i = mv;
      mst_data_i  = md;
      enable_i    = en;
      err_clear_i = clr;
      chk_valid_i = (short_lag ? p1v : p2v) ^ vflip;
      chk_data_i  = (short_lag ? p1d : p2d) ^ dx;
      @(posedge clk_i);
      #1ns;
      check(alarm_o, ea, {tag, " alarm"});
      check(err_sticky_o, es, {tag, " sticky"});
      p2v = p1v; p2d = p1d;
      p1v = mv;  p1d = md;
      @(negedge clk_i);
   endtask

   task automatic t_reset();
      rst_ni = 1'b0;
      chk_valid_i = 1'b0;
      mst_valid_i = 1'b1;
      repeat (2) @(posedge clk_i);
      #1ns;
      check(alarm_o, 1'b0, "R1 alarm in reset");
      check(err_sticky_o, 1'b0, "R1 sticky in reset");
      do_reset();
      feed(1, 32'h11, 1, 0, 0, 0, 0, 0, 0, "R1 first cycle");
   endtask

   task automatic t_arm();
      do_reset();
      feed(1, 32'h21, 1, 0, 1, 32'hFF, 0, 0, 0, "R7 cycle0 ignored");
      feed(1, 32'h22, 1, 0, 1, 32'hFF, 0, 0, 0, "R7 cycle1 ignored");
      feed(1, 32'h23, 1, 0, 1, 32'h00, 0, 1, 1, "R7 cycle2 live");
   endtask

   task automatic t_match();
      do_reset();
      for (int i = 0; i < 24; i++)
         feed((i % 3) != 0, 32'h1357_9BDF * (i + 1) ^ (32'h1 << i), 1, 0, 0, 0, 0, 0, 0,
              "R2 aligned stream");
   endtask

   task automatic t_data();
      do_reset();
      feed(1, 32'h31, 1, 0, 0, 0, 0, 0, 0, "R3 warm0");
      feed(1, 32'h32, 1, 0, 0, 0, 0, 0, 0, "R3 warm1");
      feed(1, 32'h33, 1, 0, 0, 32'h8000_0000, 0, 1, 1, "R3 msb differs");
      feed(1, 32'h34, 1, 0, 0, 0, 0, 0, 1, "R8 alarm drops");
      feed(1, 32'h35, 1, 0, 0, 32'h0001_0000, 0, 1, 1, "R8 first of two");
      feed(1, 32'h36, 1, 0, 0, 32'h0000_0001, 0, 1, 1, "R8 second of two");
      feed(1, 32'h37, 1, 0, 0, 0, 0, 0, 1, "R8 quiet again");
   endtask

   task automatic t_valid();
      do_reset();
      feed(1, 32'h41, 1, 0, 0, 0, 0, 0, 0, "R4 warm0");
      feed(1, 32'h42, 1, 0, 0, 0, 0, 0, 0, "R4 warm1");
      feed(1, 32'h43, 1, 0, 1, 0, 0, 1, 1, "R4 master1 checker0");
      feed(0, 32'h44, 1, 0, 0, 0, 0, 0, 1, "R4 clean");
      feed(1, 32'h45, 1, 0, 0, 0, 0, 0, 1, "R4 clean2");
      feed(1, 32'h46, 1, 1, 1, 0, 0, 1, 1, "R4 master0 checker1");
   endtask

   task automatic t_idle();
      do_reset();
      for (int i = 0; i < 6; i++)
         feed(0, 32'h50 + i, 1, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, "R5 idle data ignored");
   endtask

   task automatic t_enable();
      do_reset();
      feed(1, 32'h61, 1, 0, 0, 0, 0, 0, 0, "R6 warm0");
      feed(1, 32'h62, 1, 0, 0, 0, 0, 0, 0, "R6 warm1");
      feed(1, 32'h63, 0, 0, 0, 32'h0F, 0, 0, 0, "R6 disabled data");
      feed(1, 32'h64, 0, 0, 1, 0, 0, 0, 0, "R6 disabled valid");
      feed(1, 32'h65, 1, 0, 0, 32'h0F, 0, 1, 1, "R6 enabled again");
   endtask

   task automatic t_sticky();
      do_reset();
      feed(1, 32'h71, 1, 0, 0, 0, 0, 0, 0, "R9 warm0");
      feed(1, 32'h72, 1, 0, 0, 0, 0, 0, 0, "R9 warm1");
      feed(1, 32'h73, 1, 0, 0, 32'h4, 0, 1, 1, "R9 set");
      for (int i = 0; i < 3; i++)
         feed(1, 32'h74 + i, 1, 0, 0, 0, 0, 0, 1, "R9 holds");
      feed(1, 32'h78, 1, 1, 0, 0, 0, 0, 0, "R9 cleared");
      feed(1, 32'h79, 1, 0, 0, 0, 0, 0, 0, "R9 stays clear");
      feed(1, 32'h7A, 1, 1, 0, 32'h2, 0, 1, 1, "R9 clear loses to mismatch");
      feed(1, 32'h7B, 1, 1, 0, 0, 0, 0, 0, "R9 cleared again");
   endtask

   task automatic t_lag();
      do_reset();
      feed(1, 32'h100, 1, 0, 0, 0, 1, 0, 0, "R10 cycle0");
      feed(1, 32'h101, 1, 0, 0, 0, 1, 0, 0, "R10 cycle1");
      for (int i = 2; i < 6; i++)
         feed(1, 32'h100 + i, 1, 0, 0, 0, 1, 1, 1, "R10 one-cycle lag caught");
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      t_reset();
      t_arm();
      t_match();
      t_data();
      t_valid();
      t_idle();
      t_enable();
      t_sticky();
      t_lag();
      summary();
   end

   initial begin
      #(8ns * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

endmodule